// File: doc/BRIEF.md
# Nibble-Packed Video Memory Raster Scanout

This block turns a 4-bit-wide video memory into a monochrome pixel stream for a 336 × 192 visible raster. Every memory word holds four adjacent pixels. The block generates its own horizontal and vertical position counters and computes the memory address for each group of four pixels. It then shifts the returned nibble out one pixel per clock, most significant bit first. It also produces an active-video flag, horizontal and vertical sync, and pulses that mark the first pixel of each line and of each frame.

The memory is organised as character rows of scanlines. With the defaults there are 12 rows of 16 scanlines each, and every line is 84 nibbles long. The scanlines of one row sit at adjacent addresses. The nibbles along a line are therefore spaced one row-height apart.

- The first word of line `v` is at `(v / LPR) * NIB * LPR + (v % LPR)`.
- Each further nibble on that line adds `LPR`.

The memory answers one clock after it receives an address. Porch lengths, sync widths and sync polarities are parameters. The default timing has no blanking at all: a line is 336 clocks and a frame is 192 lines.

Each axis runs a four-state phase machine:

- ACTIVE goes to FRONT, FRONT goes to SYNC, SYNC goes to BACK, and BACK goes back to ACTIVE.
- A phase whose length parameter is zero is skipped in that order.
- The move back to ACTIVE is the axis wrap.
- The horizontal wrap steps the vertical machine once.

Top module: `nibble_scanout`

## Requirements
- R1: While reset is high, and during the first two clocks after it is released, the outputs are idle: pixel 0, active 0, both pulses 0, both syncs at their inactive level. After release the scan starts at pixel 0 of line 0, and `vram_addr` reads 0 during reset.
- R2: A line lasts H_ACT+H_FP+H_SW+H_BP clocks, and `pix_active` is high only for its first H_ACT pixels.
- R3: A frame lasts ROWS*LPR+V_FP+V_SW+V_BP lines, and only its first ROWS*LPR lines carry active pixels.
- R4: `hsync` is at level HS_POL exactly during pixels H_ACT+H_FP up to H_ACT+H_FP+H_SW-1 of each line. `vsync` is at level VS_POL exactly during lines ROWS*LPR+V_FP up to ROWS*LPR+V_FP+V_SW-1. Each is at the opposite level at all other times.
- R5: While the scan is at active pixel `h` of active line `v`, with `h` a multiple of 4, `vram_addr` equals `(v/LPR)*(H_ACT/4)*LPR + v%LPR + (h/4)*LPR`.
- R6: Every output is two clocks behind the internal position. Pixel `h` of an active line shows bit `3 - (h % 4)` of the word returned for its group, so bit 3 comes first and bit 0 last, with no gaps between groups.
- R7: Only bits [3:0] of `vram_data` affect the pixel. Higher bits are ignored.
- R8: `pix` is 0 whenever `pix_active` is 0.
- R9: `line_start` is high for one clock on pixel 0 of every line, including blank lines. `frame_start` is high only on pixel 0 of line 0. Both are aligned with the pixel output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| vram_addr | output | AW | Video memory read address (AW = clog2(ROWS*NIB*LPR)) |
| vram_data | input | VW | Read data, valid one clock after the address |
| pix | output | 1 | Monochrome pixel |
| pix_active | output | 1 | High inside the visible area |
| hsync | output | 1 | Horizontal sync at level HS_POL |
| vsync | output | 1 | Vertical sync at level VS_POL |
| line_start | output | 1 | Pulse on the first pixel of every line |
| frame_start | output | 1 | Pulse on the first pixel of a frame |

## Verification
The assertions check several properties on every cycle:

- Each phase counter stays inside its phase length, and a phase changes only at that phase's final count.
- Successive fetch addresses along a line differ by exactly one row-height, and every fetch address stays inside the memory.
- Sync never overlaps active video, vsync changes only at a line start, and a frame pulse always coincides with a line pulse.

Other properties need the bench's full-frame sweeps with a modelled memory. These are the absolute address formula across row boundaries, the bit order of the shifted nibble, the two-clock output alignment, the exact porch and sync placement, the ignored upper data bits, and a clean restart after a reset in the middle of a frame.

// File: rtl/scan_pkg.sv
package scan_pkg;

    // Phase of one scan axis; the order is the order in which phases follow.
    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_FRONT  = 2'd1,
        PH_SYNC   = 2'd2,
        PH_BACK   = 2'd3
    } scan_phase_e;

endpackage

// File: rtl/scan_axis.sv
// One scan axis: a phase machine plus an absolute position counter.
module scan_axis
    import scan_pkg::*;
#(
    parameter int ACT = 336,
    parameter int FP  = 0,
    parameter int SW  = 0,
    parameter int BP  = 0,
    parameter int CW  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [CW-1:0]     coord,
    output scan_phase_e       phase,
    output logic              wrap
);

    scan_phase_e   phase_q, phase_nxt;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] coord_q;
    logic          at_end;

    function automatic int unsigned span(scan_phase_e p);
        int unsigned len;
        unique case (p)
            PH_ACTIVE: len = ACT;
            PH_FRONT:  len = FP;
            PH_SYNC:   len = SW;
            PH_BACK:   len = BP;
        endcase
        return len;
    endfunction

    // Next phase in order, skipping any phase of zero length.
    function automatic scan_phase_e successor(scan_phase_e p);
        scan_phase_e nx;
        unique case (p)
            PH_ACTIVE: nx = (FP > 0) ? PH_FRONT : (SW > 0) ? PH_SYNC :
                            (BP > 0) ? PH_BACK : PH_ACTIVE;
            PH_FRONT:  nx = (SW > 0) ? PH_SYNC : (BP > 0) ? PH_BACK : PH_ACTIVE;
            PH_SYNC:   nx = (BP > 0) ? PH_BACK : PH_ACTIVE;
            PH_BACK:   nx = PH_ACTIVE;
        endcase
        return nx;
    endfunction

    assign at_end = (cnt_q == CW'(span(phase_q) - 1));

    always_comb begin
        phase_nxt = phase_q;
        if (step && at_end) begin
            phase_nxt = successor(phase_q);
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ACTIVE;
        end else begin
            phase_q <= phase_nxt;
        end
    end

    // Counters
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            coord_q <= '0;
        end else if (step) begin
            cnt_q   <= at_end ? '0 : cnt_q + 1'b1;
            coord_q <= wrap ? '0 : coord_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        phase = phase_q;
        coord = coord_q;
        wrap  = step && at_end && (successor(phase_q) == PH_ACTIVE);
    end

    p_cnt_in_span_r2: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < int'(span(phase_q)));

    p_phase_change_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_q != $past(phase_q)) |-> $past(step && at_end));

    p_coord_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (coord_q == '0));

endmodule

// File: rtl/nib_addr_gen.sv
// Computes the memory address of the current group of four pixels.
module nib_addr_gen #(
    parameter int NIB  = 84,
    parameter int LPR  = 16,
    parameter int ROWS = 12,
    parameter int AW   = 14,
    parameter int HCW  = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [HCW-1:0] hc,
    input  logic           fetch,
    input  logic           line_end,
    input  logic           frame_end,
    input  logic           v_act,
    output logic [AW-1:0]  addr
);

    localparam int ROW_SPAN = NIB * LPR;
    localparam int SLW      = (LPR > 1) ? $clog2(LPR) : 1;

    logic [AW-1:0]  row_base_q;
    logic [SLW-1:0] sl_q;

    always_ff @(posedge clk) begin
        if (rst || frame_end) begin
            row_base_q <= '0;
            sl_q       <= '0;
        end else if (line_end && v_act) begin
            if (sl_q == SLW'(LPR - 1)) begin
                sl_q       <= '0;
                row_base_q <= row_base_q + AW'(ROW_SPAN);
            end else begin
                sl_q <= sl_q + 1'b1;
            end
        end
    end

    assign addr = row_base_q + AW'(sl_q) + AW'(hc >> 2) * AW'(LPR);

    p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (fetch && hc != '0) |-> (addr == $past(addr, 4) + AW'(LPR)));

    p_addr_range_r5: assert property (@(posedge clk) disable iff (rst)
        fetch |-> (int'(addr) < ROWS * ROW_SPAN));

endmodule

// File: rtl/nib_shifter.sv
// Two-stage output path: loads the returned nibble and shifts it out MSB first.
module nib_shifter #(
    parameter int VW     = 4,
    parameter bit HS_POL = 1'b1,
    parameter bit VS_POL = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fetch,
    input  logic          act,
    input  logic          hs,
    input  logic          vs,
    input  logic          ls,
    input  logic          fs,
    input  logic [VW-1:0] rdata,
    output logic          pix,
    output logic          pix_active,
    output logic          hsync,
    output logic          vsync,
    output logic          line_start,
    output logic          frame_start
);

    logic       fetch_d, act_d, hs_d, vs_d, ls_d, fs_d;
    logic       act_q, hs_q, vs_q, ls_q, fs_q;
    logic [3:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_d <= 1'b0; act_d <= 1'b0; hs_d <= 1'b0;
            vs_d    <= 1'b0; ls_d  <= 1'b0; fs_d <= 1'b0;
            act_q   <= 1'b0; hs_q  <= 1'b0; vs_q <= 1'b0;
            ls_q    <= 1'b0; fs_q  <= 1'b0;
            sh_q    <= '0;
        end else begin
            fetch_d <= fetch; act_d <= act; hs_d <= hs;
            vs_d    <= vs;    ls_d  <= ls;  fs_d <= fs;
            act_q   <= act_d; hs_q  <= hs_d; vs_q <= vs_d;
            ls_q    <= ls_d;  fs_q  <= fs_d;
            sh_q    <= fetch_d ? rdata[3:0] : {sh_q[2:0], 1'b0};
        end
    end

    always_comb begin
        pix         = act_q & sh_q[3];
        pix_active  = act_q;
        hsync       = hs_q ? HS_POL : ~HS_POL;
        vsync       = vs_q ? VS_POL : ~VS_POL;
        line_start  = ls_q;
        frame_start = fs_q;
    end

    p_frame_on_line_r9: assert property (@(posedge clk) disable iff (rst)
        fs_q |-> ls_q);

    p_sync_blank_r4: assert property (@(posedge clk) disable iff (rst)
        hs_q |-> !act_q);

endmodule

// File: rtl/nibble_scanout.sv
module nibble_scanout
    import scan_pkg::*;
#(
    parameter int H_ACT  = 336,
    parameter int H_FP   = 0,
    parameter int H_SW   = 0,
    parameter int H_BP   = 0,
    parameter int ROWS   = 12,
    parameter int LPR    = 16,
    parameter int V_FP   = 0,
    parameter int V_SW   = 0,
    parameter int V_BP   = 0,
    parameter int VW     = 4,
    parameter bit HS_POL = 1'b1,
    parameter bit VS_POL = 1'b1,
    localparam int NIB   = H_ACT / 4,
    localparam int V_ACT = ROWS * LPR,
    localparam int HT    = H_ACT + H_FP + H_SW + H_BP,
    localparam int VT    = V_ACT + V_FP + V_SW + V_BP,
    localparam int HCW   = $clog2(HT + 1),
    localparam int VCW   = $clog2(VT + 1),
    localparam int AW    = $clog2(ROWS * NIB * LPR)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] vram_addr,
    input  logic [VW-1:0] vram_data,
    output logic          pix,
    output logic          pix_active,
    output logic          hsync,
    output logic          vsync,
    output logic          line_start,
    output logic          frame_start
);

    logic [HCW-1:0] hc;
    logic [VCW-1:0] vc;
    scan_phase_e    h_ph, v_ph;
    logic           h_wrap, v_wrap;
    logic           h_act, v_act, act, fetch;

    scan_axis #(.ACT(H_ACT), .FP(H_FP), .SW(H_SW), .BP(H_BP), .CW(HCW)) u_h_axis (
        .clk(clk), .rst(rst), .step(1'b1),
        .coord(hc), .phase(h_ph), .wrap(h_wrap)
    );

    scan_axis #(.ACT(V_ACT), .FP(V_FP), .SW(V_SW), .BP(V_BP), .CW(VCW)) u_v_axis (
        .clk(clk), .rst(rst), .step(h_wrap),
        .coord(vc), .phase(v_ph), .wrap(v_wrap)
    );

    assign h_act = (h_ph == PH_ACTIVE);
    assign v_act = (v_ph == PH_ACTIVE);
    assign act   = h_act && v_act;
    assign fetch = act && (hc[1:0] == 2'b00);

    nib_addr_gen #(.NIB(NIB), .LPR(LPR), .ROWS(ROWS), .AW(AW), .HCW(HCW)) u_addr (
        .clk(clk), .rst(rst), .hc(hc), .fetch(fetch),
        .line_end(h_wrap), .frame_end(v_wrap), .v_act(v_act),
        .addr(vram_addr)
    );

    nib_shifter #(.VW(VW), .HS_POL(HS_POL), .VS_POL(VS_POL)) u_shift (
        .clk(clk), .rst(rst), .fetch(fetch), .act(act),
        .hs(h_ph == PH_SYNC), .vs(v_ph == PH_SYNC),
        .ls(hc == '0), .fs((hc == '0) && (vc == '0)),
        .rdata(vram_data),
        .pix(pix), .pix_active(pix_active), .hsync(hsync), .vsync(vsync),
        .line_start(line_start), .frame_start(frame_start)
    );

    p_vsync_at_line_r4: assert property (@(posedge clk) disable iff (rst)
        (vsync != $past(vsync)) |-> line_start);

endmodule

// File: tb/nibble_scanout_bench.sv
`timescale 1ns/1ps
module nibble_scanout_bench;

    localparam int HA = 16, HFP = 1, HSW = 2, HBP = 1, HT = 20;
    localparam int RW = 2, LP = 4, VA = 8, VFP = 1, VSW = 1, VBP = 1, VT = 11;
    localparam int NB = 4, AWB = 5, DW = 8;
    localparam bit HP = 1'b0, VP = 1'b1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [AWB-1:0] addr;
    logic [DW-1:0]  rdata = '0;
    logic           pix, pix_active, hsync, vsync, line_start, frame_start;

    int tests = 0;
    int fails = 0;

    nibble_scanout #(
        .H_ACT(HA), .H_FP(HFP), .H_SW(HSW), .H_BP(HBP),
        .ROWS(RW), .LPR(LP), .V_FP(VFP), .V_SW(VSW), .V_BP(VBP),
        .VW(DW), .HS_POL(HP), .VS_POL(VP)
    ) u_nibble_scanout (
        .clk(clk), .rst(rst), .vram_addr(addr), .vram_data(rdata),
        .pix(pix), .pix_active(pix_active), .hsync(hsync), .vsync(vsync),
        .line_start(line_start), .frame_start(frame_start)
    );

    always #2.5 clk = ~clk;

    function automatic int nib_of(int a);
        return (a * 5 + 3 + (a >> 4) * 7) & 15;
    endfunction

    // Upper nibble is deliberately unrelated noise (R7).
    always @(posedge clk) rdata <= {4'((int'(addr) * 3 + 9) & 15), 4'(nib_of(int'(addr)))};

    function automatic int exp_addr(int v, int h);
        return (v / LP) * NB * LP + (v % LP) + (h / 4) * LP;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string tag);
        check(pix == 1'b0, {tag, " pix"}, pix, 0);
        check(pix_active == 1'b0, {tag, " active"}, pix_active, 0);
        check(line_start == 1'b0, {tag, " line_start"}, line_start, 0);
        check(frame_start == 1'b0, {tag, " frame_start"}, frame_start, 0);
        check(hsync == ~HP, {tag, " hsync"}, hsync, ~HP);
        check(vsync == ~VP, {tag, " vsync"}, vsync, ~VP);
    endtask

    task automatic check_cycle(input int n);
        int hp, vp, m, h, v, ea, eb;
        bit ha, va, ehs, evs;
        hp = n % HT;
        vp = (n / HT) % VT;
        if (hp < HA && vp < VA && hp % 4 == 0) begin
            ea = exp_addr(vp, hp);
            check(int'(addr) == ea, "R5 vram_addr", int'(addr), ea);
        end
        if (n < 2) begin
            check_idle("R1 pipeline fill");
        end else begin
            m  = n - 2;
            h  = m % HT;
            v  = (m / HT) % VT;
            ha = (h < HA);
            va = (v < VA);
            check(pix_active == (ha && va), "R2 R3 active", pix_active, int'(ha && va));
            ehs = (h >= HA + HFP && h < HA + HFP + HSW) ? HP : ~HP;
            evs = (v >= VA + VFP && v < VA + VFP + VSW) ? VP : ~VP;
            check(hsync == ehs, "R4 hsync", hsync, ehs);
            check(vsync == evs, "R4 vsync", vsync, evs);
            if (ha && va) begin
                eb = (nib_of(exp_addr(v, h)) >> (3 - h % 4)) & 1;
                check(int'(pix) == eb, "R6 R7 pixel", pix, eb);
            end else begin
                check(pix == 1'b0, "R8 blank pixel", pix, 0);
            end
            check(line_start == (h == 0), "R9 line_start", line_start, int'(h == 0));
            check(frame_start == (h == 0 && v == 0), "R9 frame_start",
                  frame_start, int'(h == 0 && v == 0));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        check(addr == '0, "R1 reset address", int'(addr), 0);
        rst = 1'b0;
        for (int i = 0; i < 3 * HT * VT; i++) begin
            check_cycle(i);
            @(negedge clk);
        end
        for (int i = 0; i < 57; i++) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_idle("R1 mid-frame reset");
        rst = 1'b0;
        for (int i = 0; i < 2 * HT * VT; i++) begin
            check_cycle(i);
            @(negedge clk);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule